// File: doc/BRIEF.md
# UART Receive Character Queue

This block sits between a UART receive shift register and the register interface. Each time the shift register finishes a character, it raises a one-cycle strobe together with the 9-bit character and that character's parity and framing error bits. The block stores the character and its two error bits in a four-entry first-in first-out queue. It always presents the oldest entry on its outputs, with that entry's own error bits. A read strobe removes the entry.

A two-bit select chooses when the receive interrupt pulses: on every stored character, when a store brings the queue to three entries, or when a store fills it. An arrival that finds the queue full sets a sticky overrun flag. While the flag is set, incoming characters are dropped and the queue is left as it is. Clearing the flag empties the queue and pulses a flush request back to the shift register. In 9-bit mode, address filtering can be switched on so that only characters with bit 8 set are stored. A receiver-idle status is taken from the shift register's busy signal.

Top module: `uart_rxq`

## Requirements
- R1: Stored characters leave the queue in arrival order. Up to DEPTH (4) characters are held. `level` gives the number held, and `rd_data` shows the oldest one.
- R2: `data_avail` is 1 exactly when `level` is nonzero. While the queue is empty, `rd_data`, `head_perr` and `head_ferr` are all 0.
- R3: `head_perr` and `head_ferr` show the error bits captured with the oldest entry, not those of the latest arrival. After a pop they show the next entry's bits.
- R4: With `int_sel` = 00 or 01, `rx_int` is high for one cycle, in the cycle after each character is stored.
- R5: With `int_sel` = 10, `rx_int` pulses only after a store that brings `level` to 3.
- R6: With `int_sel` = 11, `rx_int` pulses only after a store that brings `level` to 4.
- R7: A character that arrives while the queue is full and nothing is popped sets `overrun`. While `overrun` is 1, arrivals are dropped and `level` and the head entry stay unchanged.
- R8: An `ovr_clr` strobe while `overrun` is 1 clears `overrun`, sets `level` to 0 and drives `sr_flush` high for the following cycle. An `ovr_clr` strobe while `overrun` is 0 has no effect.
- R9: With `nine_bit` = 1 and `addr_det` = 1, a character with bit 8 = 0 is not stored, does not pulse `rx_int`, and does not set `overrun` even when the queue is full.
- R10: With `nine_bit` = 0, `addr_det` has no effect, and characters with bit 8 = 0 are stored.
- R11: `rx_idle` is 1 while `rx_busy` is 0, and 0 while `rx_busy` is 1.
- R12: After reset the queue is empty, and `overrun`, `rx_int` and `sr_flush` are 0. A `rd_stb` strobe on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chr_done | input | 1 | One-cycle strobe: the shift register has a finished character |
| chr_data | input | 9 | The finished character; bit 8 is the ninth bit |
| chr_perr | input | 1 | Parity error of the finished character |
| chr_ferr | input | 1 | Framing error of the finished character |
| rx_busy | input | 1 | The shift register is receiving a character |
| rd_stb | input | 1 | Pop the oldest entry |
| ovr_clr | input | 1 | Clear the overrun flag and flush |
| int_sel | input | 2 | Interrupt point select |
| nine_bit | input | 1 | 9-bit character mode |
| addr_det | input | 1 | Address filtering enable (takes effect only in 9-bit mode) |
| rd_data | output | 9 | Oldest character, or 0 when the queue is empty |
| head_perr | output | 1 | Parity error of the oldest character |
| head_ferr | output | 1 | Framing error of the oldest character |
| data_avail | output | 1 | The queue holds at least one character |
| level | output | 3 | Number of characters held |
| overrun | output | 1 | Sticky overrun flag |
| rx_int | output | 1 | Receive interrupt pulse |
| rx_idle | output | 1 | The receiver is idle |
| sr_flush | output | 1 | One-cycle request to empty the shift register |

## Verification
The assertions assume that `chr_done`, `rd_stb` and `ovr_clr` are single-cycle strobes. They also assume that the mode inputs `int_sel`, `nine_bit` and `addr_det` do not change in the cycle a character arrives. The stimulus drives each strobe for exactly one clock, starting at a falling edge. It changes the mode inputs only between scenarios, while no strobe is active. It never raises a read and an arrival in the same cycle, so every expected level follows a simple count.

// File: rtl/uart_rxq.sv
module uart_rxq #(
  parameter int DEPTH = 4,
  parameter int DW    = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          chr_done,
  input  logic [DW-1:0]                 chr_data,
  input  logic                          chr_perr,
  input  logic                          chr_ferr,
  input  logic                          rx_busy,
  input  logic                          rd_stb,
  input  logic                          ovr_clr,
  input  logic [1:0]                    int_sel,
  input  logic                          nine_bit,
  input  logic                          addr_det,
  output logic [DW-1:0]                 rd_data,
  output logic                          head_perr,
  output logic                          head_ferr,
  output logic                          data_avail,
  output logic [$clog2(DEPTH+1)-1:0]    level,
  output logic                          overrun,
  output logic                          rx_int,
  output logic                          rx_idle,
  output logic                          sr_flush
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [LW-1:0] TQ   = LW'((DEPTH*3)/4);

  logic [DW-1:0] mem_d [DEPTH];
  logic          mem_p [DEPTH];
  logic          mem_f [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt, cnt_nx;
  logic          ovr_q, int_q, fl_q, int_hit;

  wire addr_mode = nine_bit & addr_det;
  wire hit       = chr_done & (~addr_mode | chr_data[DW-1]);
  wire do_clr    = ovr_clr & ovr_q;
  wire do_pop    = rd_stb & (cnt != '0) & ~do_clr;
  wire room      = (cnt != FULL) | do_pop;
  wire do_push   = hit & ~ovr_q & ~do_clr & room;
  wire do_ovr    = hit & ~ovr_q & ~do_clr & ~room;

  assign cnt_nx = cnt + LW'(do_push) - LW'(do_pop);

  always_comb begin
    case (int_sel)
      2'b10:   int_hit = do_push & (cnt_nx == TQ);
      2'b11:   int_hit = do_push & (cnt_nx == FULL);
      default: int_hit = do_push;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ovr_q <= 1'b0;
      int_q <= 1'b0;
      fl_q  <= 1'b0;
    end else begin
      int_q <= int_hit;
      fl_q  <= do_clr;
      if (do_clr) begin
        wp    <= '0;
        rp    <= '0;
        cnt   <= '0;
        ovr_q <= 1'b0;
      end else begin
        if (do_push) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
        cnt <= cnt_nx;
        if (do_ovr) ovr_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_d[wp] <= chr_data;
      mem_p[wp] <= chr_perr;
      mem_f[wp] <= chr_ferr;
    end
  end

  assign data_avail = (cnt != '0);
  assign rd_data    = data_avail ? mem_d[rp] : '0;
  assign head_perr  = data_avail & mem_p[rp];
  assign head_ferr  = data_avail & mem_f[rp];
  assign level      = cnt;
  assign overrun    = ovr_q;
  assign rx_int     = int_q;
  assign sr_flush   = fl_q;
  assign rx_idle    = ~rx_busy;
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH = 4,
  parameter int DW    = 9
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       chr_done,
  input logic [DW-1:0]              chr_data,
  input logic                       rd_stb,
  input logic                       ovr_clr,
  input logic [1:0]                 int_sel,
  input logic                       nine_bit,
  input logic                       addr_det,
  input logic [DW-1:0]              rd_data,
  input logic                       head_perr,
  input logic                       head_ferr,
  input logic                       data_avail,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic                       overrun,
  input logic                       rx_int,
  input logic                       sr_flush
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH);  // R1
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !data_avail |-> (rd_data == '0 && !head_perr && !head_ferr));  // R2
  AST_INT_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && !int_sel[1] && !(nine_bit && addr_det) && !overrun && !ovr_clr && level < DEPTH) |=> rx_int);  // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);  // R7
  AST_OVR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr && !rd_stb) |=> $stable(level));  // R7
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && ovr_clr) |=> (level == '0 && !overrun && sr_flush));  // R8
  AST_ADDR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && nine_bit && addr_det && !chr_data[DW-1] && !rd_stb && !ovr_clr && !overrun)
      |=> ($stable(level) && !rx_int && !overrun));  // R9
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH), .DW(DW)) chk_i (.*);

// File: tb/uart_rxq_tb_top.sv
module uart_rxq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chr_done = 0, chr_perr = 0, chr_ferr = 0, rx_busy = 0;
  logic rd_stb = 0, ovr_clr = 0, nine_bit = 0, addr_det = 0;
  logic [8:0] chr_data = '0;
  logic [1:0] int_sel = 2'b00;
  logic [8:0] rd_data;
  logic head_perr, head_ferr, data_avail, overrun, rx_int, rx_idle, sr_flush;
  logic [2:0] level;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_rxq dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [8:0] d, input logic p, input logic f);
    @(negedge clk);
    chr_done = 1; chr_data = d; chr_perr = p; chr_ferr = f;
    @(negedge clk);
    chr_done = 0; chr_perr = 0; chr_ferr = 0;
  endtask

  task automatic pop();
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0;
  endtask

  task automatic t_reset();
    check("R12 level", level, 0);
    check("R12 overrun", overrun, 0);
    check("R12 rx_int", rx_int, 0);
    check("R12 sr_flush", sr_flush, 0);
    check("R2 avail", data_avail, 0);
    check("R2 rd_data", rd_data, 0);
  endtask

  task automatic t_order();
    int_sel = 2'b01;
    push(9'h041, 1, 0); check("R4 int1", rx_int, 1);
    push(9'h042, 0, 1); check("R4 int2", rx_int, 1);
    push(9'h043, 1, 1); check("R4 int3", rx_int, 1);
    check("R1 level", level, 3);
    check("R2 avail", data_avail, 1);
    check("R1 head", rd_data, 'h41);
    check("R3 perr0", head_perr, 1);
    check("R3 ferr0", head_ferr, 0);
    pop();
    check("R1 head2", rd_data, 'h42);
    check("R3 perr1", head_perr, 0);
    check("R3 ferr1", head_ferr, 1);
    pop();
    check("R3 ferr2", head_ferr, 1);
    pop();
    check("R2 empty data", rd_data, 0);
    check("R2 empty ferr", head_ferr, 0);
    check("R2 empty avail", data_avail, 0);
    pop();
    check("R12 pop empty", level, 0);
    push(9'h055, 0, 0);
    check("R12 after empty pop", rd_data, 'h55);
    pop();
  endtask

  task automatic t_three();
    int_sel = 2'b10;
    for (int i = 1; i <= 4; i++) begin
      push(9'(i), 0, 0);
      check("R5 int", rx_int, (i == 3) ? 1 : 0);
    end
    repeat (4) pop();
  endtask

  task automatic t_full();
    int_sel = 2'b11;
    for (int i = 1; i <= 4; i++) begin
      push(9'(16 + i), 0, 0);
      check("R6 int", rx_int, (i == 4) ? 1 : 0);
    end
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
    check("R8 clr no ovr level", level, 4);
    check("R8 clr no ovr flush", sr_flush, 0);
    push(9'h0AA, 0, 0);
    check("R7 overrun set", overrun, 1);
    check("R7 level kept", level, 4);
    check("R6 no int", rx_int, 0);
    push(9'h0BB, 0, 0);
    check("R7 still 4", level, 4);
    check("R7 head kept", rd_data, 17);
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
    check("R8 flush pulse", sr_flush, 1);
    check("R8 overrun clr", overrun, 0);
    check("R8 level 0", level, 0);
    @(negedge clk);
    check("R8 flush one cycle", sr_flush, 0);
  endtask

  task automatic t_addr();
    int_sel = 2'b00; nine_bit = 1; addr_det = 1;
    push(9'h033, 0, 0);
    check("R9 reject level", level, 0);
    check("R9 reject int", rx_int, 0);
    push(9'h133, 0, 0);
    check("R9 accept level", level, 1);
    check("R9 accept int", rx_int, 1);
    for (int i = 0; i < 3; i++) push(9'h100 + 9'(i), 0, 0);
    push(9'h077, 0, 0);
    check("R9 no overrun", overrun, 0);
    check("R9 full kept", level, 4);
    repeat (4) pop();
    nine_bit = 0;
    push(9'h033, 0, 0);
    check("R10 stored", level, 1);
    check("R10 data", rd_data, 'h33);
    pop();
    addr_det = 0;
  endtask

  task automatic t_idle();
    @(negedge clk); rx_busy = 1;
    #1 check("R11 busy", rx_idle, 0);
    @(negedge clk); rx_busy = 0;
    #1 check("R11 idle", rx_idle, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_three();
    t_full();
    t_addr();
    t_idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule